// File: doc/BRIEF.md
# Double-Buffered DMA Channel

This block moves 32-bit words between a card-interface peripheral and memory, in both directions. Each direction holds two buffer descriptors. The active descriptor is a pointer and a word count. The queued descriptor has the same shape. Software programs both through a small register bus. When the active count runs out and a queued buffer is waiting, the block moves the queued buffer into the active slot at the same clock edge. Two buffers therefore chain with no idle cycle between them.

On the receive side, each word that the peripheral offers is written to memory at the active pointer. On the transmit side, each word is read from memory at the active pointer and handed to the peripheral. Four level flags report the state of each direction:

- an end flag, raised when the active count is zero;
- a full flag (receive) or an empty flag (transmit), raised when both counts are zero.

A control register turns each direction on and off.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset, every pointer and count is zero, both directions are off, and all four status flags read 1.
- R2: Registers are selected by word index. Receive: 0 active pointer, 1 active count, 2 queued pointer, 3 queued count. Transmit: 4 to 7, in the same order. Control: 8. Each count keeps only the low 16 bits of the written value. Pointers read back in full.
- R3: A word moves only in a cycle where all of the following hold: the direction is on, its active count is nonzero, and both sides of the handshake are ready. For receive, those are `rx_valid` and `mem_wr_gnt`. For transmit, those are `tx_ready` and `mem_rd_gnt`. At most one word moves per direction per cycle.
- R4: Each moved word uses the active pointer as its memory address. The pointer then advances by 4 and the count drops by 1. Receive writes `rx_data` to memory. Transmit passes `mem_rd_data` to `tx_data`.
- R5: Suppose a transfer brings the active count to zero while the queued count is nonzero. At that same edge, the queued pointer and count become active and the queued count is cleared. The next word then moves in the following cycle, with no gap.
- R6: Suppose the active count is already zero when a nonzero queued count is written. The queued buffer becomes active on the edge after the write.
- R7: The end flag equals (active count == 0). The full or empty flag equals (both counts == 0). Both flags drop as soon as a nonzero count has been written.
- R8: Control write bits are: bit 0 receive on, bit 1 receive off, bit 2 transmit on, bit 3 transmit off. Reading control returns bit 0 = receive on and bit 1 = transmit on.
- R9: If the on bit and the off bit for the same direction are written together, the direction ends up off.
- R10: Writing both off bits stops both directions. No further words move, and the counts hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| rx_valid | input | 1 | Peripheral has a received word |
| rx_data | input | 32 | Received word |
| rx_take | output | 1 | Received word consumed this cycle |
| tx_ready | input | 1 | Peripheral can accept a word |
| tx_data | output | 32 | Word to transmit |
| tx_push | output | 1 | Transmit word delivered this cycle |
| mem_wr_req | output | 1 | Memory write request (receive path) |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_gnt | input | 1 | Memory write accepted this cycle |
| mem_rd_req | output | 1 | Memory read request (transmit path) |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_data | input | 32 | Memory read data, valid with grant |
| mem_rd_gnt | input | 1 | Memory read accepted this cycle |
| rx_end | output | 1 | Receive active count is zero |
| rx_full | output | 1 | Both receive counts are zero |
| tx_end | output | 1 | Transmit active count is zero |
| tx_empty | output | 1 | Both transmit counts are zero |

## Verification
Some properties are checked by assertions on every cycle:

- a word never moves while a direction is off or its count is empty;
- each word steps the pointer by 4 and the count by 1;
- a chained buffer takes over at the edge where the active count runs out;
- a set full or empty flag implies a set end flag;
- an off bit always leaves its direction off.

Other behaviour can only be shown by the bench's scenarios:

- the exact order of memory addresses and data across two chained buffers;
- a queued buffer taking over from an idle channel;
- transmit throttling by the peripheral;
- counts staying frozen after a stop.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
  localparam int N_DIR   = 2;
  localparam int N_SLOT  = 4;
  localparam int DIR_RX  = 0;
  localparam int DIR_TX  = 1;
  // Slot order inside one direction; the register index decodes it.
  localparam int S_CUR_PTR = 0;
  localparam int S_CUR_CNT = 1;
  localparam int S_NXT_PTR = 2;
  localparam int S_NXT_CNT = 3;
  localparam int REG_AW    = 4;
  localparam logic [REG_AW-1:0] CTL_IDX = 4'd8;
endpackage

// File: rtl/dbd_rst_sync.sv
module dbd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dbd_lane.sv
module dbd_lane
  import dbd_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              xfer_i,
  input  logic [N_SLOT-1:0] wr_sel_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [AW-1:0]     cur_ptr_o,
  output logic [CW-1:0]     cur_cnt_o,
  output logic [AW-1:0]     nxt_ptr_o,
  output logic [CW-1:0]     nxt_cnt_o,
  output logic              busy_o,
  output logic              end_o,
  output logic              done_o
);
  localparam int WORD_BYTES = DW / 8;

  logic [AW-1:0] cur_ptr_q, cur_ptr_d, nxt_ptr_q, nxt_ptr_d;
  logic [CW-1:0] cur_cnt_q, cur_cnt_d, nxt_cnt_q, nxt_cnt_d;
  logic [CW-1:0] eff_cnt;
  logic          reload;
  logic          cur_ptr_ce, cur_cnt_ce, nxt_ptr_ce, nxt_cnt_ce;

  always_comb begin
    eff_cnt = xfer_i ? (cur_cnt_q - CW'(1)) : cur_cnt_q;
    reload  = !wr_sel_i[S_CUR_CNT] && (eff_cnt == '0) && (nxt_cnt_q != '0);

    cur_ptr_ce = wr_sel_i[S_CUR_PTR] | reload | xfer_i;
    if (wr_sel_i[S_CUR_PTR]) cur_ptr_d = wdata_i[AW-1:0];
    else if (reload)         cur_ptr_d = nxt_ptr_q;
    else                     cur_ptr_d = cur_ptr_q + AW'(WORD_BYTES);

    cur_cnt_ce = wr_sel_i[S_CUR_CNT] | reload | xfer_i;
    if (wr_sel_i[S_CUR_CNT]) cur_cnt_d = wdata_i[CW-1:0];
    else if (reload)         cur_cnt_d = nxt_cnt_q;
    else                     cur_cnt_d = eff_cnt;

    nxt_ptr_ce = wr_sel_i[S_NXT_PTR];
    nxt_ptr_d  = wdata_i[AW-1:0];

    nxt_cnt_ce = wr_sel_i[S_NXT_CNT] | reload;
    nxt_cnt_d  = wr_sel_i[S_NXT_CNT] ? wdata_i[CW-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ptr_q <= '0;
      cur_cnt_q <= '0;
      nxt_ptr_q <= '0;
      nxt_cnt_q <= '0;
    end else begin
      if (cur_ptr_ce) cur_ptr_q <= cur_ptr_d;
      if (cur_cnt_ce) cur_cnt_q <= cur_cnt_d;
      if (nxt_ptr_ce) nxt_ptr_q <= nxt_ptr_d;
      if (nxt_cnt_ce) nxt_cnt_q <= nxt_cnt_d;
    end
  end

  assign cur_ptr_o = cur_ptr_q;
  assign cur_cnt_o = cur_cnt_q;
  assign nxt_ptr_o = nxt_ptr_q;
  assign nxt_cnt_o = nxt_cnt_q;
  assign busy_o    = (cur_cnt_q != '0);
  assign end_o     = (cur_cnt_q == '0);
  assign done_o    = (cur_cnt_q == '0) && (nxt_cnt_q == '0);

  AST_NO_IDLE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_i |-> (en_i && busy_o)); // R3

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && wr_sel_i == '0 && cur_cnt_q > CW'(1))
    |=> (cur_cnt_q == $past(cur_cnt_q) - CW'(1)) &&
        (cur_ptr_q == $past(cur_ptr_q) + AW'(WORD_BYTES))); // R4

  AST_CHAIN_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && wr_sel_i == '0 && cur_cnt_q == CW'(1) && nxt_cnt_q != '0)
    |=> (cur_cnt_q == $past(nxt_cnt_q)) && (cur_ptr_q == $past(nxt_ptr_q)) &&
        (nxt_cnt_q == '0)); // R5

  AST_DONE_IMPLIES_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> end_o); // R7
endmodule

// File: rtl/dbd_regs.sv
module dbd_regs
  import dbd_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [REG_AW-1:0]           reg_addr,
  input  logic [DW-1:0]               reg_wdata,
  output logic [DW-1:0]               reg_rdata,
  input  logic [N_DIR-1:0][AW-1:0]    cur_ptr_i,
  input  logic [N_DIR-1:0][CW-1:0]    cur_cnt_i,
  input  logic [N_DIR-1:0][AW-1:0]    nxt_ptr_i,
  input  logic [N_DIR-1:0][CW-1:0]    nxt_cnt_i,
  output logic [N_DIR-1:0][N_SLOT-1:0] wr_sel_o,
  output logic [N_DIR-1:0]            en_o
);
  logic [N_DIR-1:0] en_q, en_d;
  logic             ctl_wr;
  logic             rd_dir;
  logic [1:0]       rd_slot;

  assign ctl_wr  = reg_wr && (reg_addr == CTL_IDX);
  assign rd_dir  = reg_addr[2];
  assign rd_slot = reg_addr[1:0];

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      assign wr_sel_o[d][s] = reg_wr && !reg_addr[3] &&
                              (reg_addr[2] == 1'(d)) && (reg_addr[1:0] == 2'(s));
    end
    // Off bit is applied after the on bit, so off wins a same-cycle clash.
    always_comb begin
      en_d[d] = en_q[d];
      if (ctl_wr) en_d[d] = (en_q[d] | reg_wdata[2*d]) & ~reg_wdata[2*d+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (ctl_wr) en_q <= en_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTL_IDX) begin
      reg_rdata[N_DIR-1:0] = en_q;
    end else if (!reg_addr[3]) begin
      case (rd_slot)
        2'(S_CUR_PTR): reg_rdata = DW'(cur_ptr_i[rd_dir]);
        2'(S_CUR_CNT): reg_rdata = DW'(cur_cnt_i[rd_dir]);
        2'(S_NXT_PTR): reg_rdata = DW'(nxt_ptr_i[rd_dir]);
        default:       reg_rdata = DW'(nxt_cnt_i[rd_dir]);
      endcase
    end
  end

  assign en_o = en_q;

  AST_RX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[1]) |=> !en_o[DIR_RX]); // R9

  AST_TX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[3]) |=> !en_o[DIR_TX]); // R10

  AST_RX_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[0] && !reg_wdata[1]) |=> en_o[DIR_RX]); // R8
endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbd_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_data,
  output logic              rx_take,
  input  logic              tx_ready,
  output logic [DW-1:0]     tx_data,
  output logic              tx_push,
  output logic              mem_wr_req,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [DW-1:0]     mem_wr_data,
  input  logic              mem_wr_gnt,
  output logic              mem_rd_req,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [DW-1:0]     mem_rd_data,
  input  logic              mem_rd_gnt,
  output logic              rx_end,
  output logic              rx_full,
  output logic              tx_end,
  output logic              tx_empty
);
  logic                         rst_int_n;
  logic [N_DIR-1:0][AW-1:0]     cur_ptr, nxt_ptr;
  logic [N_DIR-1:0][CW-1:0]     cur_cnt, nxt_cnt;
  logic [N_DIR-1:0][N_SLOT-1:0] wr_sel;
  logic [N_DIR-1:0]             en, busy, xfer, end_flag, done_flag, side_ok, req;

  dbd_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dbd_regs #(.AW(AW), .CW(CW), .DW(DW)) i_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cur_ptr_i (cur_ptr),
    .cur_cnt_i (cur_cnt),
    .nxt_ptr_i (nxt_ptr),
    .nxt_cnt_i (nxt_cnt),
    .wr_sel_o  (wr_sel),
    .en_o      (en)
  );

  assign side_ok[DIR_RX] = rx_valid;
  assign side_ok[DIR_TX] = tx_ready;

  for (genvar d = 0; d < N_DIR; d++) begin : g_lane
    dbd_lane #(.AW(AW), .CW(CW), .DW(DW)) i_lane (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .en_i      (en[d]),
      .xfer_i    (xfer[d]),
      .wr_sel_i  (wr_sel[d]),
      .wdata_i   (reg_wdata),
      .cur_ptr_o (cur_ptr[d]),
      .cur_cnt_o (cur_cnt[d]),
      .nxt_ptr_o (nxt_ptr[d]),
      .nxt_cnt_o (nxt_cnt[d]),
      .busy_o    (busy[d]),
      .end_o     (end_flag[d]),
      .done_o    (done_flag[d])
    );
    assign req[d] = en[d] && busy[d] && side_ok[d];
  end

  assign xfer[DIR_RX] = req[DIR_RX] && mem_wr_gnt;
  assign xfer[DIR_TX] = req[DIR_TX] && mem_rd_gnt;

  assign mem_wr_req  = req[DIR_RX];
  assign mem_wr_addr = cur_ptr[DIR_RX];
  assign mem_wr_data = rx_data;
  assign rx_take     = xfer[DIR_RX];

  assign mem_rd_req  = req[DIR_TX];
  assign mem_rd_addr = cur_ptr[DIR_TX];
  assign tx_data     = mem_rd_data;
  assign tx_push     = xfer[DIR_TX];

  assign rx_end   = end_flag[DIR_RX];
  assign rx_full  = done_flag[DIR_RX];
  assign tx_end   = end_flag[DIR_TX];
  assign tx_empty = done_flag[DIR_TX];
endmodule

// File: tb/test_dbuf_dma_chan.sv
module test_dbuf_dma_chan;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rx_valid, rx_take, tx_ready, tx_push;
  logic [31:0] rx_data, tx_data;
  logic        mem_wr_req, mem_wr_gnt, mem_rd_req, mem_rd_gnt;
  logic [31:0] mem_wr_addr, mem_wr_data, mem_rd_addr, mem_rd_data;
  logic        rx_end, rx_full, tx_end, tx_empty;

  logic        rx_hold, tx_hold, tx_pat, rx_took;
  logic [15:0] rx_seq, exp_seq;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] rxq_addr[$], rxq_data[$], txq_addr[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rx_valid    = !rx_hold;
  assign tx_ready    = !tx_hold && tx_pat;
  assign rx_data     = {16'hC0DE, rx_seq};
  assign mem_rd_data = mem_rd_addr ^ KEY;
  assign mem_wr_gnt  = 1'b1;
  assign mem_rd_gnt  = 1'b1;

  dbuf_dma_chan i_dbuf_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_take(rx_take), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_push(tx_push), .mem_wr_req(mem_wr_req),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_gnt(mem_wr_gnt), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_rd_gnt(mem_rd_gnt), .rx_end(rx_end), .rx_full(rx_full),
    .tx_end(tx_end), .tx_empty(tx_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  // Driver side of the scoreboard: expected memory traffic per buffer.
  task automatic plan_rx(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      rxq_addr.push_back(base + 32'(4*i));
      rxq_data.push_back({16'hC0DE, exp_seq});
      exp_seq++;
    end
  endtask

  task automatic plan_tx(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) txq_addr.push_back(base + 32'(4*i));
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor side of the scoreboard.
  initial begin
    rx_took = 1'b0;
    rx_seq  = '0;
    forever begin
      @(negedge clk);
      if (rx_took) rx_seq++;
      rx_took = 1'b0;
      #1;
      if (rst_n && rx_take) begin
        rx_took = 1'b1;
        if (rxq_addr.size() == 0) chk("R3 unexpected rx word", mem_wr_addr, 32'hFFFF_FFFF);
        else begin
          chk("R4 rx address", mem_wr_addr, rxq_addr.pop_front());
          chk("R4 rx data", mem_wr_data, rxq_data.pop_front());
        end
      end
      if (rst_n && tx_push) begin
        if (txq_addr.size() == 0) chk("R3 unexpected tx word", mem_rd_addr, 32'hFFFF_FFFF);
        else begin
          logic [31:0] a;
          a = txq_addr.pop_front();
          chk("R4 tx address", mem_rd_addr, a);
          chk("R4 tx data", tx_data, a ^ KEY);
        end
      end
    end
  end

  initial begin
    tx_pat = 1'b0;
    forever begin
      @(posedge clk); #1;
      tx_pat = ~tx_pat;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    exp_seq = '0;
    rx_hold = 1'b0; tx_hold = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    chk("R1 rx_end", 32'(rx_end), 1); chk("R1 rx_full", 32'(rx_full), 1);
    chk("R1 tx_end", 32'(tx_end), 1); chk("R1 tx_empty", 32'(tx_empty), 1);
    rd(8, v); chk("R1 control", v, 0);
    rd(0, v); chk("R1 rx pointer", v, 0);
    rd(5, v); chk("R1 tx count", v, 0);

    // R5 two receive buffers chained
    wr(0, 32'h1000); wr(1, 3); wr(2, 32'h2000); wr(3, 2);
    @(negedge clk);
    chk("R7 rx_end cleared", 32'(rx_end), 0);
    chk("R7 rx_full cleared", 32'(rx_full), 0);
    chk("R3 no request while off", 32'(mem_wr_req), 0);
    plan_rx(32'h1000, 3); plan_rx(32'h2000, 2);
    wr(8, 32'h1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(1, v); chk("R5 count after swap", v, 2);
    rd(0, v); chk("R5 pointer after swap", v, 32'h2000);
    rd(3, v); chk("R5 queued count cleared", v, 0);
    chk("R5 no end pulse at swap", 32'(rx_end), 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5 gap-free drain rx_full", 32'(rx_full), 1);
    chk("R7 rx_end at drain", 32'(rx_end), 1);
    chk("R5 all rx words seen", 32'(rxq_addr.size()), 0);
    rd(0, v); chk("R4 final rx pointer", v, 32'h2008);
    wr(8, 32'h2);

    // R6 queued buffer on an idle channel
    wr(2, 32'h6000); wr(3, 1);
    @(posedge clk); @(negedge clk);
    rd(1, v); chk("R6 idle swap count", v, 1);
    rd(0, v); chk("R6 idle swap pointer", v, 32'h6000);
    rd(3, v); chk("R6 queued cleared", v, 0);
    wr(2, 32'h4000); wr(3, 2);

    // R2 field widths
    wr(6, 32'h1234_5678); wr(7, 32'hFFFF_0000);
    @(negedge clk);
    rd(6, v); chk("R2 pointer read-back", v, 32'h1234_5678);
    rd(7, v); chk("R2 count truncated", v, 0);

    // Transmit with peripheral throttling
    wr(4, 32'h3000); wr(5, 4);
    @(negedge clk);
    chk("R7 tx_end cleared", 32'(tx_end), 0);
    chk("R7 tx_empty cleared", 32'(tx_empty), 0);
    plan_tx(32'h3000, 4);
    wr(8, 32'h4);
    for (int i = 0; i < 40 && !tx_empty; i++) @(negedge clk);
    @(negedge clk);
    chk("R3 tx drained under stalls", 32'(txq_addr.size()), 0);
    chk("R7 tx_empty set", 32'(tx_empty), 1);
    wr(8, 32'h8);

    // R9 on and off together
    wr(8, 32'h3);
    @(negedge clk);
    rd(8, v); chk("R9 off wins", v, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(1, v); chk("R9 rx count untouched", v, 1);

    // R8 / R10 enable both, then stop both
    rx_hold = 1'b1; tx_hold = 1'b1;
    wr(4, 32'h7000); wr(5, 2);
    wr(8, 32'h5);
    @(negedge clk);
    rd(8, v); chk("R8 both on", v, 3);
    wr(8, 32'hA);
    @(negedge clk);
    rd(8, v); chk("R10 both off", v, 0);
    rx_hold = 1'b0; tx_hold = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd(1, v); chk("R10 rx count held", v, 1);
    rd(5, v); chk("R10 tx count held", v, 2);
    chk("R10 no rx request", 32'(mem_wr_req), 0);

    // Restart both directions and drain everything queued
    plan_rx(32'h6000, 1); plan_rx(32'h4000, 2);
    plan_tx(32'h7000, 2);
    wr(8, 32'h5);
    for (int i = 0; i < 40 && !(rx_full && tx_empty); i++) @(negedge clk);
    @(negedge clk);
    chk("R5 rx final queue", 32'(rxq_addr.size()), 0);
    chk("R4 tx final queue", 32'(txq_addr.size()), 0);
    chk("R7 rx_full final", 32'(rx_full), 1);
    chk("R7 tx_empty final", 32'(tx_empty), 1);
    finish_run();
  end
endmodule